// File: doc/BRIEF.md
# Debug Trigger Chain Resolver

This block sits between the match comparators of ten hardware debug triggers and the trap logic of a processor pipeline. Each cycle it receives a raw hit bit per trigger and decides which triggers really fire. It also decides whether the resulting debug trap is taken before the current instruction or after it. The triggers form five fixed pairs. Pair p holds triggers 2p and 2p+1. The pairs watch, in order: fetch/fetch, store/store, load/load, fetch/store and fetch/load accesses.

A pair can be chained. A chained pair fires only when both members hit and both members ask for the same trap timing. Per-trigger enables, timing bits and per-pair chain bits are held in registers loaded through a single write port. Two configurations are illegal: chaining the store/store pair, and data-value comparison on a load-watching trigger. The port refuses either one, leaves the trigger it addressed disabled, and pulses an error flag.

The hit, fire and trap outputs are combinational in the hit inputs. A clear input forces them all low, for use during a pipeline flush.

Top module: `debug_trigger_resolver`

## Requirements
- R1: While reset is asserted and after it is released, all triggers are disabled and all chain bits are clear. With any hit pattern, fire_o, trap_now_o, trap_next_o, any_hit_o and cfg_err_o are all 0.
- R2: For a pair whose chain bit is clear, trigger k fires (fire_o[k]=1) exactly when hit_i[k] is 1 and trigger k is enabled.
- R3: For a pair whose chain bit is set, both members fire only when all of the following hold: both hit, both are enabled, and both timing bits are equal. Otherwise neither member fires.
- R4: A chained pair whose two timing bits differ never fires, whatever its hits.
- R5: Timing bit 0 means trap before the instruction and timing bit 1 means trap after it. trap_now_o is the OR of fired triggers with timing 0. trap_next_o is the OR of fired triggers with timing 1. any_hit_o is the OR of all fire_o bits.
- R6: A write (cfg_we_i=1 at a rising edge) to index k in 0..9 loads three things: the enable of trigger k from cfg_enable_i, its timing from cfg_timing_i, and chain bit k>>1 from cfg_chain_i. The new values act from the cycle after the write. During the write cycle the old values still govern. A write to an index of 10 or more changes nothing and raises no error.
- R7: A write with cfg_chain_i=1 to trigger 2 or 3 (the store/store pair) is refused. Chain bit 1 stays clear, and the addressed trigger is left disabled.
- R8: A write with cfg_data_sel_i=1 (data-value comparison) is refused when it targets a load-watching trigger (4, 5 or 9), and that trigger is left disabled. The same select on any other trigger is accepted.
- R9: While clear_i is 1, fire_o, trap_now_o, trap_next_o and any_hit_o are 0 in that same cycle.
- R10: cfg_err_o is 1 for exactly the cycle after a refused write, and 0 in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_idx_i | input | 4 | Trigger index addressed by the write |
| cfg_enable_i | input | 1 | Enable value for the addressed trigger |
| cfg_timing_i | input | 1 | Timing value: 0 trap before, 1 trap after |
| cfg_data_sel_i | input | 1 | 1 selects data-value comparison, 0 address comparison |
| cfg_chain_i | input | 1 | Chain value for the pair of the addressed trigger |
| hit_i | input | 10 | Raw comparator hit per trigger |
| clear_i | input | 1 | Flush: forces all fire and trap outputs low |
| fire_o | output | 10 | Triggers that actually fire |
| any_hit_o | output | 1 | OR of fire_o |
| trap_now_o | output | 1 | Trap before the current instruction |
| trap_next_o | output | 1 | Trap after the current instruction |
| cfg_err_o | output | 1 | Pulse one cycle after a refused write |

## Verification
Every pair is swept through all 32 combinations of its two enables, two timing bits and chain bit, against all four hit patterns of the pair. This separates independent firing from chained firing, and matched timing from mismatched timing. On the store/store pair the same sweep also exercises refused chaining. A second pass holds a mixed configuration across all five pairs and applies all 1024 hit patterns. That pass shows that pairs do not disturb each other and that the two trap outputs split correctly by timing. Directed writes cover data-value selection on load and non-load triggers, out-of-range indices, the cycle in which a write becomes visible, and clear during active hits.

// File: rtl/dtr_pkg.sv
package dtr_pkg;

  typedef enum logic [1:0] {
    KIND_FETCH = 2'd0,
    KIND_STORE = 2'd1,
    KIND_LOAD  = 2'd2
  } acc_kind_e;

  // Access kind watched by one member of a fixed pair.
  function automatic acc_kind_e member_kind(input int pair, input int member);
    acc_kind_e k;
    case (pair)
      0:       k = KIND_FETCH;
      1:       k = KIND_STORE;
      2:       k = KIND_LOAD;
      3:       k = (member == 0) ? KIND_FETCH : KIND_STORE;
      4:       k = (member == 0) ? KIND_FETCH : KIND_LOAD;
      default: k = KIND_FETCH;
    endcase
    return k;
  endfunction

  // A pair of two store watchers may not be linked.
  function automatic logic chain_permitted(input int pair);
    return !((member_kind(pair, 0) == KIND_STORE) &&
             (member_kind(pair, 1) == KIND_STORE));
  endfunction

  // Load watchers may not compare data values.
  function automatic logic data_cmp_permitted(input acc_kind_e k);
    return (k != KIND_LOAD);
  endfunction

endpackage

// File: rtl/dtr_cfg_regs.sv
module dtr_cfg_regs
  import dtr_pkg::*;
#(
  parameter  int NUM_PAIRS = 5,
  localparam int NUM_TRIG  = 2 * NUM_PAIRS,
  localparam int IDX_W     = $clog2(NUM_TRIG)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we_i,
  input  logic [IDX_W-1:0]     cfg_idx_i,
  input  logic                 cfg_enable_i,
  input  logic                 cfg_timing_i,
  input  logic                 cfg_data_sel_i,
  input  logic                 cfg_chain_i,
  output logic [NUM_TRIG-1:0]  en_q_o,
  output logic [NUM_TRIG-1:0]  timing_q_o,
  output logic [NUM_PAIRS-1:0] chain_q_o,
  output logic                 err_q_o
);

  function automatic logic [NUM_TRIG-1:0] f_data_ok();
    logic [NUM_TRIG-1:0] m;
    for (int i = 0; i < NUM_TRIG; i++)
      m[i] = data_cmp_permitted(member_kind(i / 2, i % 2));
    return m;
  endfunction

  function automatic logic [NUM_PAIRS-1:0] f_chain_ok();
    logic [NUM_PAIRS-1:0] m;
    for (int p = 0; p < NUM_PAIRS; p++)
      m[p] = chain_permitted(p);
    return m;
  endfunction

  localparam logic [NUM_TRIG-1:0]  DATA_OK  = f_data_ok();
  localparam logic [NUM_PAIRS-1:0] CHAIN_OK = f_chain_ok();

  logic [NUM_TRIG-1:0]  en_q, en_d;
  logic [NUM_TRIG-1:0]  timing_q, timing_d;
  logic [NUM_PAIRS-1:0] chain_q, chain_d;
  logic                 err_q, err_d;
  logic                 in_range;
  logic                 cfg_upd;
  logic [IDX_W-2:0]     pair_sel;
  logic                 chain_bad;
  logic                 data_bad;
  logic                 refuse;

  assign in_range  = (int'(cfg_idx_i) < NUM_TRIG);
  assign cfg_upd   = cfg_we_i && in_range;
  assign pair_sel  = cfg_idx_i[IDX_W-1:1];
  assign chain_bad = in_range && cfg_chain_i && !CHAIN_OK[pair_sel];
  assign data_bad  = in_range && cfg_data_sel_i && !DATA_OK[cfg_idx_i];
  assign refuse    = chain_bad || data_bad;

  // Next-state
  always_comb begin
    en_d     = en_q;
    timing_d = timing_q;
    chain_d  = chain_q;
    if (cfg_upd) begin
      en_d[cfg_idx_i]     = cfg_enable_i && !refuse;
      timing_d[cfg_idx_i] = cfg_timing_i;
      if (!chain_bad)
        chain_d[pair_sel] = cfg_chain_i;
    end
    err_d = cfg_upd && refuse;
  end

  // Registers, written only on an accepted-index strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= '0;
      timing_q <= '0;
      chain_q  <= '0;
    end else if (cfg_upd) begin
      en_q     <= en_d;
      timing_q <= timing_d;
      chain_q  <= chain_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_d;
  end

  assign en_q_o     = en_q;
  assign timing_q_o = timing_q;
  assign chain_q_o  = chain_q;
  assign err_q_o    = err_q;

  // R7
  store_chain_never_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chain_q & ~CHAIN_OK) == '0);

  // R8
  load_data_refused_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we_i && cfg_data_sel_i && in_range && !DATA_OK[cfg_idx_i])
      |=> (en_q[$past(cfg_idx_i)] == 1'b0));

  // R6
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we_i |=> ($stable(en_q) && $stable(timing_q) && $stable(chain_q)));

  // R10
  err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we_i && in_range && (cfg_chain_i && !CHAIN_OK[pair_sel]))
      |=> err_q);

endmodule

// File: rtl/dtr_pair_resolver.sv
module dtr_pair_resolver
  import dtr_pkg::*;
#(
  parameter int PAIR_IDX = 0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear_i,
  input  logic       chain_i,
  input  logic [1:0] hit_i,
  input  logic [1:0] en_i,
  input  logic [1:0] timing_i,
  output logic [1:0] fire_o
);

  logic [1:0] qual;
  logic       link;
  logic       same_timing;
  logic [1:0] fire_d;

  assign qual        = hit_i & en_i;
  assign same_timing = (timing_i[0] == timing_i[1]);

  // Pairs that may never be linked ignore the chain input entirely
  generate
    if (chain_permitted(PAIR_IDX)) begin : g_linkable
      assign link = chain_i;
    end else begin : g_unlinkable
      assign link = 1'b0;
    end
  endgenerate

  always_comb begin
    if (clear_i)
      fire_d = 2'b00;
    else if (link)
      fire_d = ((&qual) && same_timing) ? 2'b11 : 2'b00;
    else
      fire_d = qual;
  end

  assign fire_o = fire_d;

  // R2
  fire_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_o & ~(hit_i & en_i)) == 2'b00);

  // R3
  chained_together_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chain_i |-> (fire_o[0] == fire_o[1]));

  // R4
  timing_split_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chain_i && chain_permitted(PAIR_IDX) && (timing_i[0] != timing_i[1]))
      |-> (fire_o == 2'b00));

endmodule

// File: rtl/debug_trigger_resolver.sv
module debug_trigger_resolver
  import dtr_pkg::*;
#(
  parameter  int NUM_PAIRS = 5,
  localparam int NUM_TRIG  = 2 * NUM_PAIRS,
  localparam int IDX_W     = $clog2(NUM_TRIG)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we_i,
  input  logic [IDX_W-1:0]    cfg_idx_i,
  input  logic                cfg_enable_i,
  input  logic                cfg_timing_i,
  input  logic                cfg_data_sel_i,
  input  logic                cfg_chain_i,
  input  logic [NUM_TRIG-1:0] hit_i,
  input  logic                clear_i,
  output logic [NUM_TRIG-1:0] fire_o,
  output logic                any_hit_o,
  output logic                trap_now_o,
  output logic                trap_next_o,
  output logic                cfg_err_o
);

  logic [NUM_TRIG-1:0]  en_q;
  logic [NUM_TRIG-1:0]  timing_q;
  logic [NUM_PAIRS-1:0] chain_q;
  logic [NUM_TRIG-1:0]  fire;

  dtr_cfg_regs #(.NUM_PAIRS(NUM_PAIRS)) u_cfg (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfg_we_i       (cfg_we_i),
    .cfg_idx_i      (cfg_idx_i),
    .cfg_enable_i   (cfg_enable_i),
    .cfg_timing_i   (cfg_timing_i),
    .cfg_data_sel_i (cfg_data_sel_i),
    .cfg_chain_i    (cfg_chain_i),
    .en_q_o         (en_q),
    .timing_q_o     (timing_q),
    .chain_q_o      (chain_q),
    .err_q_o        (cfg_err_o)
  );

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    dtr_pair_resolver #(.PAIR_IDX(p)) u_pair (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear_i  (clear_i),
      .chain_i  (chain_q[p]),
      .hit_i    (hit_i[2*p+1:2*p]),
      .en_i     (en_q[2*p+1:2*p]),
      .timing_i (timing_q[2*p+1:2*p]),
      .fire_o   (fire[2*p+1:2*p])
    );
  end

  assign fire_o      = fire;
  assign any_hit_o   = |fire;
  assign trap_now_o  = |(fire & ~timing_q);
  assign trap_next_o = |(fire & timing_q);

  // R5
  trap_split_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any_hit_o == (trap_now_o || trap_next_o));

  // R9
  clear_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |-> (fire_o == '0 && !trap_now_o && !trap_next_o && !any_hit_o));

endmodule

// File: tb/debug_trigger_resolver_tb.sv
`timescale 1ns/1ps
module debug_trigger_resolver_tb;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg_we_i, cfg_enable_i, cfg_timing_i, cfg_data_sel_i, cfg_chain_i;
  logic [3:0] cfg_idx_i;
  logic [9:0] hit_i;
  logic       clear_i;
  logic [9:0] fire_o;
  logic       any_hit_o, trap_now_o, trap_next_o, cfg_err_o;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 0;

  bit m_en [10];
  bit m_tm [10];
  bit m_ch [5];

  always #2 clk = ~clk;

  debug_trigger_resolver u_dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_we_i(cfg_we_i), .cfg_idx_i(cfg_idx_i), .cfg_enable_i(cfg_enable_i),
    .cfg_timing_i(cfg_timing_i), .cfg_data_sel_i(cfg_data_sel_i),
    .cfg_chain_i(cfg_chain_i), .hit_i(hit_i), .clear_i(clear_i),
    .fire_o(fire_o), .any_hit_o(any_hit_o), .trap_now_o(trap_now_o),
    .trap_next_o(trap_next_o), .cfg_err_o(cfg_err_o)
  );

  function automatic bit is_load(int i);
    return (i == 4) || (i == 5) || (i == 9);
  endfunction

  function automatic logic [9:0] model_fire(logic [9:0] h, bit clr);
    logic [9:0] f = '0;
    if (!clr) begin
      for (int p = 0; p < 5; p++) begin
        bit a = m_en[2*p] && h[2*p];
        bit b = m_en[2*p+1] && h[2*p+1];
        if (m_ch[p]) begin
          if (a && b && (m_tm[2*p] == m_tm[2*p+1])) begin
            f[2*p] = 1'b1; f[2*p+1] = 1'b1;
          end
        end else begin
          f[2*p] = a; f[2*p+1] = b;
        end
      end
    end
    return f;
  endfunction

  task automatic check_out(string tag);
    logic [9:0] ef = model_fire(hit_i, clear_i);
    bit en_now = 0, en_next = 0;
    for (int i = 0; i < 10; i++) begin
      if (ef[i] && !m_tm[i]) en_now  = 1;
      if (ef[i] &&  m_tm[i]) en_next = 1;
    end
    n_vec++;
    if (fire_o !== ef || trap_now_o !== en_now || trap_next_o !== en_next ||
        any_hit_o !== (|ef)) begin
      n_bad++;
      $display("FAIL %s: hit=%b fire=%b now=%b next=%b any=%b, expected fire=%b now=%b next=%b any=%b",
               tag, hit_i, fire_o, trap_now_o, trap_next_o, any_hit_o,
               ef, en_now, en_next, |ef);
    end
  endtask

  task automatic check_err(bit exp, string tag);
    n_vec++;
    if (cfg_err_o !== exp) begin
      n_bad++;
      $display("FAIL %s: cfg_err=%b expected %b", tag, cfg_err_o, exp);
    end
  endtask

  task automatic drive_hits(logic [9:0] h, bit clr, string tag);
    @(negedge clk);
    hit_i   = h;
    clear_i = clr;
    #1;
    check_out(tag);
  endtask

  task automatic write_cfg(int idx, bit en, bit tm, bit sel, bit ch, string tag);
    bit exp_err = 0;
    @(negedge clk);
    cfg_we_i = 1; cfg_idx_i = 4'(idx); cfg_enable_i = en;
    cfg_timing_i = tm; cfg_data_sel_i = sel; cfg_chain_i = ch;
    #1;
    check_out("R6 old config during write");
    if (idx < 10) begin
      int  p = idx / 2;
      bit  cbad = ch && (p == 1);
      bit  dbad = sel && is_load(idx);
      m_en[idx] = en && !(cbad || dbad);
      m_tm[idx] = tm;
      if (!cbad) m_ch[p] = ch;
      exp_err = cbad || dbad;
    end
    @(negedge clk);
    cfg_we_i = 0;
    #1;
    check_err(exp_err, tag);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; cfg_we_i = 0; cfg_idx_i = '0; cfg_enable_i = 0; cfg_timing_i = 0;
    cfg_data_sel_i = 0; cfg_chain_i = 0; hit_i = '0; clear_i = 0;
    for (int i = 0; i < 10; i++) begin m_en[i] = 0; m_tm[i] = 0; end
    for (int p = 0; p < 5; p++) m_ch[p] = 0;

    // R1: reset state
    repeat (3) @(negedge clk);
    hit_i = 10'h3FF; #1;
    check_out("R1 in reset");
    check_err(1'b0, "R1 in reset");
    @(negedge clk); rst_n = 1;
    drive_hits(10'h3FF, 0, "R1 after release");
    check_err(1'b0, "R1 after release");
    drive_hits(10'h000, 0, "R1 idle");

    // Per-pair exhaustive sweep: R2, R3, R4, R5, R7, R10
    for (int p = 0; p < 5; p++) begin
      for (int code = 0; code < 32; code++) begin
        bit en0 = code[0], en1 = code[1], t0 = code[2], t1 = code[3], ch = code[4];
        write_cfg(2*p+1, en1, t1, 0, 0, "R6 odd member write");
        write_cfg(2*p,   en0, t0, 0, ch, (p == 1 && ch) ? "R7,R10 store chain" : "R6,R10 even write");
        for (int h = 0; h < 4; h++) begin
          string tag;
          if (!m_ch[p])          tag = (p == 1 && ch) ? "R7 refused chain" : "R2,R5 unchained";
          else if (t0 == t1)     tag = "R3,R5 chained";
          else                   tag = "R4 chained timing mismatch";
          drive_hits(10'(h) << (2*p), 0, tag);
        end
      end
      write_cfg(2*p,   0, 0, 0, 0, "R6 disable");
      write_cfg(2*p+1, 0, 0, 0, 0, "R6 disable");
    end

    // R8: data-value select on load and non-load watchers
    write_cfg(4, 1, 0, 1, 0, "R8 load data select refused");
    drive_hits(10'h030, 0, "R8 trigger 4 disabled");
    write_cfg(9, 1, 1, 1, 0, "R8 load data select refused");
    drive_hits(10'h200, 0, "R8 trigger 9 disabled");
    write_cfg(6, 1, 1, 1, 0, "R8 fetch data select accepted");
    write_cfg(7, 1, 0, 1, 0, "R8 store data select accepted");
    drive_hits(10'h0C0, 0, "R8 triggers 6,7 fire");
    write_cfg(5, 1, 1, 0, 0, "R8 address select accepted");
    drive_hits(10'h020, 0, "R8 trigger 5 fires");

    // R6: out-of-range index ignored
    write_cfg(0, 1, 0, 0, 0, "R6 setup");
    write_cfg(12, 0, 1, 1, 1, "R6 out of range no error");
    write_cfg(15, 0, 1, 0, 1, "R6 out of range no error");
    drive_hits(10'h001, 0, "R6 out of range left trigger 0");

    // Mixed configuration across all pairs, all hit patterns: R5
    write_cfg(1, 1, 0, 0, 1, "R6 mix");
    write_cfg(2, 1, 1, 0, 0, "R6 mix");
    write_cfg(3, 1, 0, 0, 0, "R6 mix");
    write_cfg(4, 1, 0, 0, 0, "R6 mix");
    write_cfg(5, 1, 1, 0, 1, "R6 mix");
    write_cfg(6, 1, 1, 0, 0, "R6 mix");
    write_cfg(7, 1, 1, 0, 1, "R6 mix");
    write_cfg(8, 1, 0, 0, 0, "R6 mix");
    write_cfg(9, 0, 1, 0, 0, "R6 mix");
    for (int h = 0; h < 1024; h++)
      drive_hits(10'(h), 0, "R5 mixed sweep");

    // R9: clear overrides active hits
    drive_hits(10'h3FF, 1, "R9 clear all hits");
    drive_hits(10'h0C3, 1, "R9 clear chained hits");
    drive_hits(10'h0C3, 0, "R9 after clear");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule